// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer

This block is the digital half of an 8-bit successive-approximation analog-to-digital converter inside a microcontroller peripheral. It drives a trial code to an external resistor-ladder DAC and reads back one comparator bit, which tells it whether the analog input lies above the ladder voltage. Starting from a cleared code, it tries each bit from the most significant to the least significant. After the eighth decision it raises a completion flag and, if so configured, an interrupt request.

Software reaches the block over a small register bus with three registers. The control register (address 0) holds the channel select, the ladder supply-connect enable and the completion bit. Writing 0 to the completion bit starts a conversion. The result register (address 1) holds the trial code, which is the finished result once the completion bit reads 1. The interrupt register (address 2) holds a source select and a request flag. That flag is shared between conversion completion and an external interrupt pin. The comparator, the ladder and the input multiplexer live outside the block.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset, the control register reads 0x80 (completion bit 7 set, all other bits 0). The result register, the interrupt register, `dacCode`, `chanSel`, `ladderOn` and `irqReq` are all 0.
- R2: A write to address 0 with bit 7 = 0 starts a conversion, and bit 7 of address 0 reads 0 until the conversion ends. A write with bit 7 = 1 starts nothing.
- R3: On the clock edge that accepts a start write, the result register (and `dacCode`) becomes 0x00.
- R4: Trials run from bit 7 down to bit 0, six cycles each. A trial sets its bit to 1 and drives the code on `dacCode`. At the trial's last cycle the bit stays 1 if `cmpHigh` = 1 (input above the ladder voltage), otherwise it is cleared. After the start edge, bit 7-k is set at edge 1+6k, and the final code is the result.
- R5: Bit 7 of address 0 returns to 1 exactly on the 50th clock edge after the start edge, and never later.
- R6: With bit 7 of address 2 = 1 (completion source), `irqReq` (bit 0 of address 2) becomes 1 on the same edge as the completion bit.
- R7: Starting a conversion does not clear `irqReq`. A write to address 2 with bit 0 = 0 clears it. Writing 1 to bit 0 has no effect. A set event wins over a clearing write in the same cycle.
- R8: With bit 7 of address 2 = 0 (pin source), `irqReq` is set by a rising edge on `extIrq`, and conversion completion does not set it.
- R9: Bits [2:0] of address 0 drive `chanSel`, and bit 3 drives `ladderOn`. Any write to address 0 updates bits [6:0], which read back as written.
- R10: A start write during a running conversion restarts it from the beginning. Completion then arrives 50 edges after the latest start.
- R11: While a conversion runs, the result register returns the partial trial code (0x80 during the first trial).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Register address |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for `addr` (combinational) |
| cmpHigh | input | 1 | Comparator: 1 when the input is above the ladder voltage |
| extIrq | input | 1 | External interrupt pin |
| dacCode | output | 8 | Trial code to the ladder DAC |
| chanSel | output | 3 | Analog channel select |
| ladderOn | output | 1 | Ladder supply-connect enable |
| irqReq | output | 1 | Shared interrupt request flag |

## Verification
The hardest situation to reach is a restart in the middle of a conversion that coincides with a pending interrupt flag. Here the code must drop to zero, the flag must survive, and the completion count must start again. The bench starts one conversion and rewrites the start bit twenty cycles later, while the flag from an earlier completion is still set. It then follows every trial edge of the restarted conversion. A behavioural comparator driven from `dacCode` supplies input levels at 0, at full scale, and exactly on a code boundary.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int CODE_W = 8;
  localparam int IDX_W = $clog2(CODE_W);

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_RESULT = 2'd1;
  localparam logic [1:0] ADDR_IRQ = 2'd2;

  localparam int CHAN_W = 3;
  localparam int LADDER_BIT = 3;
  localparam int DONE_BIT = 7;
  localparam int IRQ_FLAG_BIT = 0;
  localparam int IRQ_SRC_BIT = 7;

  typedef struct packed {
    logic clear;
    logic setBit;
    logic [IDX_W-1:0] setIdx;
    logic dropBit;
    logic [IDX_W-1:0] dropIdx;
  } dpCmd_t;

  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_TRIAL, ST_STORE} sarState_t;
endpackage

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_pkg::*;
#(
  parameter int TRIAL_CYC = 6
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   startPulse,
  input  logic   cmpHigh,
  output dpCmd_t cmd,
  output logic   done,
  output logic   convDone
);
  localparam int CNT_W = (TRIAL_CYC > 1) ? $clog2(TRIAL_CYC) : 1;
  localparam int TOTAL_CYC = CODE_W * TRIAL_CYC + 2;
  localparam int EL_W = $clog2(TOTAL_CYC + 1);

  sarState_t stateQ;
  logic [IDX_W-1:0] bitIdxQ;
  logic [CNT_W-1:0] cntQ;
  logic doneQ;
  logic lastCyc;
  logic [EL_W-1:0] elapsedQ;

  assign lastCyc = (cntQ == CNT_W'(TRIAL_CYC - 1));
  assign done = doneQ;
  assign convDone = (stateQ == ST_STORE) && !startPulse;

  always_comb begin
    cmd = '0;
    cmd.clear = startPulse;
    cmd.dropIdx = bitIdxQ;
    cmd.setIdx = bitIdxQ - IDX_W'(1);
    if (!startPulse) begin
      if (stateQ == ST_SETUP) begin
        cmd.setBit = 1'b1;
        cmd.setIdx = IDX_W'(CODE_W - 1);
      end else if (stateQ == ST_TRIAL && lastCyc) begin
        cmd.dropBit = !cmpHigh;
        cmd.setBit = (bitIdxQ != '0);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      bitIdxQ <= '0;
      cntQ <= '0;
      doneQ <= 1'b1;
    end else if (startPulse) begin
      stateQ <= ST_SETUP;
      bitIdxQ <= IDX_W'(CODE_W - 1);
      cntQ <= '0;
      doneQ <= 1'b0;
    end else begin
      unique case (stateQ)
        ST_IDLE: ;
        ST_SETUP: begin
          stateQ <= ST_TRIAL;
          cntQ <= '0;
        end
        ST_TRIAL: begin
          if (lastCyc) begin
            cntQ <= '0;
            if (bitIdxQ == '0) stateQ <= ST_STORE;
            else bitIdxQ <= bitIdxQ - IDX_W'(1);
          end else begin
            cntQ <= cntQ + CNT_W'(1);
          end
        end
        ST_STORE: begin
          stateQ <= ST_IDLE;
          doneQ <= 1'b1;
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  // cycles since the latest start, for the budget check only
  always_ff @(posedge clk) begin
    if (!rstN) elapsedQ <= '0;
    else if (startPulse) elapsedQ <= EL_W'(1);
    else if (!doneQ) elapsedQ <= elapsedQ + EL_W'(1);
  end

  AST_DONE_LOW_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ != ST_IDLE) |-> !doneQ); // R2
  AST_WITHIN_BUDGET: assert property (@(posedge clk) disable iff (!rstN)
    !doneQ |-> (elapsedQ <= EL_W'(TOTAL_CYC))); // R5
  AST_RESTART_FROM_TOP: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> (stateQ == ST_SETUP && !doneQ)); // R10
endmodule

// File: rtl/sar_datapath.sv
module sar_datapath
  import sar_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  output logic [CODE_W-1:0] code
);
  logic [CODE_W-1:0] codeQ, codeD;

  always_comb begin
    codeD = codeQ;
    if (cmd.clear) begin
      codeD = '0;
    end else begin
      if (cmd.dropBit) codeD[cmd.dropIdx] = 1'b0;
      if (cmd.setBit) codeD[cmd.setIdx] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) codeQ <= '0;
    else codeQ <= codeD;
  end

  assign code = codeQ;

  AST_CLEAR_ON_START: assert property (@(posedge clk) disable iff (!rstN)
    cmd.clear |=> (codeQ == '0)); // R3
  AST_TRIAL_BIT_SET: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.setBit && !cmd.clear) |=> codeQ[$past(cmd.setIdx)]); // R4
  AST_LOWER_BITS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.setBit && !cmd.clear) |-> ((codeQ & ((CODE_W'(1) << cmd.setIdx) - CODE_W'(1))) == '0)); // R4
endmodule

// File: rtl/sar_regfile.sv
module sar_regfile
  import sar_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        addr,
  input  logic              wrEn,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  input  logic [CODE_W-1:0] code,
  input  logic              done,
  input  logic              convDone,
  input  logic              extIrq,
  output logic              startPulse,
  output logic [CHAN_W-1:0] chanSel,
  output logic              ladderOn,
  output logic              irqReq
);
  logic [6:0] ctrlQ;
  logic srcSelQ, irqQ, extQ;
  logic ctrlWr, irqWr, irqSet, irqClr;

  assign ctrlWr = wrEn && (addr == ADDR_CTRL);
  assign irqWr = wrEn && (addr == ADDR_IRQ);
  assign startPulse = ctrlWr && !wrData[DONE_BIT];
  assign irqSet = srcSelQ ? convDone : (extIrq && !extQ);
  assign irqClr = irqWr && !wrData[IRQ_FLAG_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ <= '0;
      srcSelQ <= 1'b0;
      irqQ <= 1'b0;
      extQ <= 1'b0;
    end else begin
      extQ <= extIrq;
      if (ctrlWr) ctrlQ <= wrData[6:0];
      if (irqWr) srcSelQ <= wrData[IRQ_SRC_BIT];
      if (irqSet) irqQ <= 1'b1;
      else if (irqClr) irqQ <= 1'b0;
    end
  end

  assign chanSel = ctrlQ[CHAN_W-1:0];
  assign ladderOn = ctrlQ[LADDER_BIT];
  assign irqReq = irqQ;

  always_comb begin
    rdData = '0;
    unique case (addr)
      ADDR_CTRL: rdData = {done, ctrlQ};
      ADDR_RESULT: rdData = 8'(code);
      ADDR_IRQ: begin
        rdData[IRQ_SRC_BIT] = srcSelQ;
        rdData[IRQ_FLAG_BIT] = irqQ;
      end
      default: rdData = '0;
    endcase
  end

  AST_IRQ_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (convDone && srcSelQ) |=> irqQ); // R6
  AST_IRQ_KEPT_ON_START: assert property (@(posedge clk) disable iff (!rstN)
    (startPulse && irqQ) |=> irqQ); // R7
  AST_PIN_MODE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!srcSelQ && !irqQ && !(extIrq && !extQ)) |=> !irqQ); // R8
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
  import sar_pkg::*;
#(
  parameter int TRIAL_CYC = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        addr,
  input  logic              wrEn,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  input  logic              cmpHigh,
  input  logic              extIrq,
  output logic [CODE_W-1:0] dacCode,
  output logic [CHAN_W-1:0] chanSel,
  output logic              ladderOn,
  output logic              irqReq
);
  dpCmd_t cmd;
  logic startPulse, done, convDone;
  logic [CODE_W-1:0] code;

  sar_ctrl #(.TRIAL_CYC(TRIAL_CYC)) ctrl_i (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .cmpHigh(cmpHigh),
    .cmd(cmd), .done(done), .convDone(convDone)
  );

  sar_datapath dp_i (.clk(clk), .rstN(rstN), .cmd(cmd), .code(code));

  sar_regfile regs_i (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .code(code), .done(done), .convDone(convDone),
    .extIrq(extIrq), .startPulse(startPulse), .chanSel(chanSel),
    .ladderOn(ladderOn), .irqReq(irqReq)
  );

  assign dacCode = code;
endmodule

// File: tb/sar_adc_ctrl_tb_top.sv
module sar_adc_ctrl_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] addr = '0;
  logic wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic cmpHigh;
  logic extIrq = 1'b0;
  logic [7:0] dacCode;
  logic [2:0] chanSel;
  logic ladderOn, irqReq;

  int vin2 = 0;  // analog input in half-LSB units
  int errors = 0, checks = 0, cyc = 0;
  logic [7:0] curCtrl = 8'h00;

  // reference model state
  int mdlLeft = 0;
  bit mdlIrq = 0, mdlSrc = 0, mdlExtPrev = 0;
  logic [2:0] mdlChan = '0;
  bit mdlLadder = 0;

  always #4 clk = ~clk;

  assign cmpHigh = (2 * int'(dacCode)) < vin2;

  sar_adc_ctrl dut_i (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .cmpHigh(cmpHigh), .extIrq(extIrq), .dacCode(dacCode),
    .chanSel(chanSel), .ladderOn(ladderOn), .irqReq(irqReq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int sarExp(input int v);
    int c = 0;
    for (int b = 7; b >= 0; b--) begin
      int t = c | (1 << b);
      if (2 * t < v) c = t;
    end
    return c;
  endfunction

  // behavioural model, updated on every edge
  always @(posedge clk) begin
    bit setEv, startEv, clrEv;
    if (!rstN) begin
      mdlLeft = 0; mdlIrq = 0; mdlSrc = 0; mdlExtPrev = 0;
      mdlChan = '0; mdlLadder = 0;
    end else begin
      startEv = wrEn && addr == 2'd0 && !wrData[7];
      clrEv = wrEn && addr == 2'd2 && !wrData[0];
      setEv = 0;
      if (startEv) mdlLeft = 50;
      else if (mdlLeft > 0) begin
        if (mdlLeft == 1 && mdlSrc) setEv = 1;
        mdlLeft--;
      end
      if (!mdlSrc && extIrq && !mdlExtPrev) setEv = 1;
      if (setEv) mdlIrq = 1;
      else if (clrEv) mdlIrq = 0;
      if (wrEn && addr == 2'd2) mdlSrc = wrData[7];
      if (wrEn && addr == 2'd0) begin
        mdlChan = wrData[2:0];
        mdlLadder = wrData[3];
      end
      mdlExtPrev = extIrq;
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      chk(irqReq == mdlIrq, "R6/R8 irq vs model", irqReq, mdlIrq);
      chk({ladderOn, chanSel} == {mdlLadder, mdlChan}, "R9 ctrl outputs", {ladderOn, chanSel}, {mdlLadder, mdlChan});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=0x%0h expected=0x0", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; addr = 2'd0; wrData = '0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] v);
    addr = a;
    #1;
    v = rdData;
    addr = 2'd0;
  endtask

  task automatic startConv(input int v);
    vin2 = v;
    busWrite(2'd0, curCtrl & 8'h7F);
  endtask

  task automatic convAndCheck(input int v);
    int exp = sarExp(v);
    bit irqBefore = irqReq;
    logic [7:0] r;
    startConv(v);
    peek(2'd1, r); chk(r == 8'h00, "R3 cleared at start", r, 0);
    peek(2'd0, r); chk(r[7] == 1'b0, "R2 busy reads 0", r[7], 0);
    chk(irqReq == irqBefore, "R7 start keeps irq", irqReq, irqBefore);
    for (int i = 1; i <= 50; i++) begin
      @(negedge clk);
      for (int k = 0; k < 8; k++) begin
        if (i == 2 + 6 * k) begin
          int pre = exp & ~((1 << (8 - k)) - 1);
          int want = pre | (1 << (7 - k));
          chk(int'(dacCode) == want, "R4 trial code", dacCode, want);
          if (k == 0) begin
            peek(2'd1, r); chk(r == 8'h80, "R11 partial read", r, 8'h80);
          end
        end
      end
      if (i == 49) begin
        peek(2'd0, r); chk(r[7] == 1'b0, "R5 not done at 49", r[7], 0);
      end
      if (i == 50) begin
        peek(2'd0, r); chk(r[7] == 1'b1, "R5 done at 50", r[7], 1);
        peek(2'd1, r); chk(int'(r) == exp, "R4 result", r, exp);
      end
    end
  endtask

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    peek(2'd0, r); chk(r == 8'h80, "R1 ctrl reset", r, 8'h80);
    peek(2'd1, r); chk(r == 8'h00, "R1 result reset", r, 0);
    peek(2'd2, r); chk(r == 8'h00, "R1 irq reg reset", r, 0);
    chk({dacCode, chanSel, ladderOn, irqReq} == '0, "R1 outputs reset", {dacCode, chanSel, ladderOn, irqReq}, 0);

    curCtrl = 8'h0D;
    busWrite(2'd0, 8'h8D);
    repeat (3) @(negedge clk);
    peek(2'd0, r); chk(r == 8'h8D, "R2 write 1 no start / R9 readback", r, 8'h8D);
    chk(chanSel == 3'd5 && ladderOn, "R9 chan and ladder", {ladderOn, chanSel}, 4'hD);

    busWrite(2'd2, 8'h80);
    convAndCheck(2 * 8'h5A + 1);
    chk(irqReq == 1'b1, "R6 irq on completion", irqReq, 1);
    convAndCheck(2 * 8'h33);
    busWrite(2'd2, 8'h81);
    chk(irqReq == 1'b1, "R7 write 1 no effect", irqReq, 1);
    busWrite(2'd2, 8'h80);
    chk(irqReq == 1'b0, "R7 write 0 clears", irqReq, 0);

    convAndCheck(0);
    convAndCheck(600);

    startConv(2 * 8'h10 + 1);
    repeat (20) @(negedge clk);
    convAndCheck(2 * 8'hC3 + 1);  // R10 restart mid-run

    busWrite(2'd2, 8'h00);
    convAndCheck(2 * 8'h21 + 1);
    chk(irqReq == 1'b0, "R8 completion ignored in pin mode", irqReq, 0);
    @(negedge clk); extIrq = 1'b1;
    @(negedge clk);
    chk(irqReq == 1'b1, "R8 pin edge sets irq", irqReq, 1);
    extIrq = 1'b0;
    busWrite(2'd2, 8'h00);
    chk(irqReq == 1'b0, "R8 cleared", irqReq, 0);

    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule